// File: doc/BRIEF.md
# Two-Client SDRAM Request Arbiter

This block shares one single-port SDRAM controller between two clients. The read client, on the video-out side, fetches bursts from memory. The write client, on the video-in side, stores bursts into memory. The controller only ever sees one request source.

After reset the arbiter stays idle until the controller reports that its initialisation is complete. From then on it looks at both clients' request lines in the same cycle and grants one of them. If both are asking, the read client wins. The arbiter then presents the winner's address and the matching read or write request to the controller, and holds them until the controller takes the request. While the burst runs, the controller's accept, word-strobe and done signals are passed back to the granted client only.

When the controller signals that the burst is done, the arbiter goes back to polling. If neither client is asking, it keeps polling every cycle. Clients sit on a priority-ordered vector, so adding a port means extending that vector and adding one busy state.

Top module: `sdram_port_arbiter`

## Requirements
- R1: After reset, and for as long as `init_done` has not been sampled high, `ctl_rd_req` and `ctl_wr_req` stay 0. All client handshake outputs also stay 0, whatever the client requests are.
- R2: On the first rising edge where `init_done` is 1, the arbiter begins polling. A client request sampled on the next edge produces a controller request in the cycle after that edge.
- R3: When `rd_req` and `wr_req` are both 1 on the polling edge, the read client is granted: `ctl_rd_req` becomes 1 and `ctl_addr` equals `rd_addr`.
- R4: When only one client requests on a polling edge, that client is granted. When none requests, no controller request is raised and polling repeats on every following edge.
- R5: `ctl_rd_req` and `ctl_wr_req` are never 1 together. No new controller request is raised while a granted burst has not been ended by `ctl_done`.
- R6: From grant until the edge where `ctl_accept` is 1, the request line and `ctl_addr` stay unchanged, even if the client changes its address or drops its request. In the cycle after that edge, the request line is 0.
- R7: `ctl_addr` carries the address the granted client presented on the grant edge.
- R8: `ctl_accept`, `ctl_word` and `ctl_done` are copied combinationally to the granted client's `*_accept`, `*_word` and `*_done` outputs. The other client's copies stay 0, and all copies are 0 when no client holds a grant.
- R9: A grant ends only on an edge where `ctl_done` is 1. The cycle after that edge is a polling cycle with no controller request. A client still requesting then is granted on the following edge.
- R10: Once polling has started, `init_done` has no further effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Controller has finished initialisation |
| rd_req | input | 1 | Read client asks for a burst |
| rd_addr | input | ADDR_W | Read client burst address |
| wr_req | input | 1 | Write client asks for a burst |
| wr_addr | input | ADDR_W | Write client burst address |
| ctl_accept | input | 1 | Controller takes the pending request |
| ctl_word | input | 1 | Controller moves one data word |
| ctl_done | input | 1 | Controller finished the burst |
| ctl_rd_req | output | 1 | Read request to controller |
| ctl_wr_req | output | 1 | Write request to controller |
| ctl_addr | output | ADDR_W | Burst address to controller |
| rd_accept | output | 1 | Accept routed to read client |
| rd_word | output | 1 | Word strobe routed to read client |
| rd_done | output | 1 | Done routed to read client |
| wr_accept | output | 1 | Accept routed to write client |
| wr_word | output | 1 | Word strobe routed to write client |
| wr_done | output | 1 | Done routed to write client |

## Verification
A state register stuck in or wrongly entering a busy state shows up within one cycle. It appears as a controller request with no client asking, or as handshake strobes reaching the wrong client. A lost pending flag shows as a request that drops before `ctl_accept`, or that never drops after it, one edge after the fault. A wrong priority or a skipped polling cycle shows as the wrong request line, or a request one cycle early, on the cycle right after the polling edge.

// File: rtl/sdram_arb_pkg.sv
// Shared definitions for the SDRAM request arbiter.
// Assumes port index 0 has the highest poll priority.
package sdram_arb_pkg;
    localparam int N_PORTS = 2;
    localparam int PORT_RD = 0;   // read client: highest priority
    localparam int PORT_WR = 1;   // write client

    typedef enum logic [1:0] {
        INIT_WAIT,
        POLL,
        READ_BUSY,
        WRITE_BUSY
    } arb_state_t;
endpackage

// File: rtl/arb_poll_pick.sv
// Fixed-priority picker over N request lines; lower index wins.
// Assumes requests are sampled together in one cycle.
module arb_poll_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         hit
);
    // each port wins only if no lower-index port asks
    assign pick[0] = req[0];
    generate
        for (genvar i = 1; i < N; i++) begin : g_chain
            assign pick[i] = req[i] & ~(|req[i-1:0]);
        end
    endgenerate

    // any request present
    assign hit = |req;
endmodule

// File: rtl/arb_fsm.sv
// Grant state machine: waits for controller init, polls, holds a grant
// until the controller reports the burst is done. Latches the winner's
// address and keeps the request pending until the controller accepts it.
// Assumes the controller accepts a request before it reports done.
module arb_fsm
    import sdram_arb_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int N      = N_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic [N-1:0]      pick,
    input  logic              hit,
    input  logic [N*ADDR_W-1:0] cli_addr,
    input  logic              ctl_accept,
    input  logic              ctl_done,
    output arb_state_t        state,
    output logic              pending,
    output logic [ADDR_W-1:0] addr_q
);
    arb_state_t        state_nx;
    logic [ADDR_W-1:0] sel_addr;

    // select the winning client's address
    always_comb begin
        sel_addr = '0;
        for (int i = 0; i < N; i++) begin
            if (pick[i]) sel_addr |= cli_addr[i*ADDR_W +: ADDR_W];
        end
    end

    // next-state decode, poll order follows port index
    always_comb begin
        state_nx = state;
        unique case (state)
            INIT_WAIT:  if (init_done) state_nx = POLL;
            POLL: begin
                if (hit) begin
                    if (pick[PORT_RD])      state_nx = READ_BUSY;
                    else if (pick[PORT_WR]) state_nx = WRITE_BUSY;
                end
            end
            READ_BUSY:  if (ctl_done) state_nx = POLL;
            WRITE_BUSY: if (ctl_done) state_nx = POLL;
            default:    state_nx = INIT_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= INIT_WAIT;
        else        state <= state_nx;
    end

    // pending flag and address capture at grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            addr_q  <= '0;
        end else if (state == POLL && hit) begin
            pending <= 1'b1;
            addr_q  <= sel_addr;
        end else if (ctl_accept || ctl_done) begin
            pending <= 1'b0;
        end
    end

    // R1
    init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == INIT_WAIT && !init_done) |=> (state == INIT_WAIT && !pending));

    // R3
    rd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == POLL && pick[PORT_RD]) |=> (state == READ_BUSY && pending));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ctl_accept && !ctl_done) |=>
            (pending && $stable(addr_q) && $stable(state)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == READ_BUSY || state == WRITE_BUSY) && !ctl_done) |=> $stable(state));
endmodule

// File: rtl/arb_route.sv
// Steers controller handshake strobes to the client holding the grant.
// Assumes gnt is one-hot or zero.
module arb_route #(
    parameter int N = 2
) (
    input  logic [N-1:0] gnt,
    input  logic         ctl_accept,
    input  logic         ctl_word,
    input  logic         ctl_done,
    output logic [N-1:0] cli_accept,
    output logic [N-1:0] cli_word,
    output logic [N-1:0] cli_done
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_port
            // gate each strobe with this port's grant
            assign cli_accept[i] = gnt[i] & ctl_accept;
            assign cli_word[i]   = gnt[i] & ctl_word;
            assign cli_done[i]   = gnt[i] & ctl_done;
        end
    endgenerate
endmodule

// File: rtl/sdram_port_arbiter.sv
// Two-client arbiter in front of a single-port SDRAM controller.
// Read client has priority on ties; one request outstanding at a time.
// Assumes controller strobes are single-cycle and synchronous to clk.
module sdram_port_arbiter
    import sdram_arb_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              ctl_accept,
    input  logic              ctl_word,
    input  logic              ctl_done,
    output logic              ctl_rd_req,
    output logic              ctl_wr_req,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic              rd_accept,
    output logic              rd_word,
    output logic              rd_done,
    output logic              wr_accept,
    output logic              wr_word,
    output logic              wr_done
);
    localparam int N = N_PORTS;

    logic [N-1:0]        req_v, pick_v, gnt_v;
    logic [N-1:0]        acc_v, word_v, done_v;
    logic [N*ADDR_W-1:0] addr_v;
    logic                hit, pending;
    arb_state_t          state;

    // pack client ports into priority-ordered vectors
    assign req_v[PORT_RD] = rd_req;
    assign req_v[PORT_WR] = wr_req;
    assign addr_v[PORT_RD*ADDR_W +: ADDR_W] = rd_addr;
    assign addr_v[PORT_WR*ADDR_W +: ADDR_W] = wr_addr;

    arb_poll_pick #(.N(N)) u_pick (
        .req  (req_v),
        .pick (pick_v),
        .hit  (hit)
    );

    arb_fsm #(.ADDR_W(ADDR_W), .N(N)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_done  (init_done),
        .pick       (pick_v),
        .hit        (hit),
        .cli_addr   (addr_v),
        .ctl_accept (ctl_accept),
        .ctl_done   (ctl_done),
        .state      (state),
        .pending    (pending),
        .addr_q     (ctl_addr)
    );

    // grant vector from busy state
    assign gnt_v[PORT_RD] = (state == READ_BUSY);
    assign gnt_v[PORT_WR] = (state == WRITE_BUSY);

    // requests to controller while the grant is not yet accepted
    assign ctl_rd_req = pending & gnt_v[PORT_RD];
    assign ctl_wr_req = pending & gnt_v[PORT_WR];

    arb_route #(.N(N)) u_route (
        .gnt        (gnt_v),
        .ctl_accept (ctl_accept),
        .ctl_word   (ctl_word),
        .ctl_done   (ctl_done),
        .cli_accept (acc_v),
        .cli_word   (word_v),
        .cli_done   (done_v)
    );

    // unpack routed strobes to client ports
    assign rd_accept = acc_v[PORT_RD];
    assign rd_word   = word_v[PORT_RD];
    assign rd_done   = done_v[PORT_RD];
    assign wr_accept = acc_v[PORT_WR];
    assign wr_word   = word_v[PORT_WR];
    assign wr_done   = done_v[PORT_WR];

    // R5
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_rd_req && ctl_wr_req));

    // R5
    no_rereq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_rd_req || ctl_wr_req) && ctl_accept && !ctl_done) |=>
            (!ctl_rd_req && !ctl_wr_req));

    // R8
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_accept || rd_word || rd_done, wr_accept || wr_word || wr_done}));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_req && !ctl_accept && !ctl_done) |=> (ctl_rd_req && $stable(ctl_addr)));
endmodule

// File: tb/tb_sdram_port_arbiter.sv
module tb_sdram_port_arbiter;
    localparam int AW = 22;

    logic clk = 1'b0;
    logic rst_n, init_done, rd_req, wr_req, ctl_accept, ctl_word, ctl_done;
    logic [AW-1:0] rd_addr, wr_addr, ctl_addr;
    logic ctl_rd_req, ctl_wr_req, rd_accept, rd_word, rd_done;
    logic wr_accept, wr_word, wr_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sdram_port_arbiter #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr),
        .ctl_accept(ctl_accept), .ctl_word(ctl_word), .ctl_done(ctl_done),
        .ctl_rd_req(ctl_rd_req), .ctl_wr_req(ctl_wr_req), .ctl_addr(ctl_addr),
        .rd_accept(rd_accept), .rd_word(rd_word), .rd_done(rd_done),
        .wr_accept(wr_accept), .wr_word(wr_word), .wr_done(wr_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // vector: {rd_req, wr_req, exp_rd_grant, exp_wr_grant}
    localparam logic [3:0] VEC [0:5] = '{
        4'b0000, 4'b1010, 4'b0101, 4'b1110, 4'b0000, 4'b1110
    };

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; init_done = 0; rd_req = 0; wr_req = 0;
        ctl_accept = 0; ctl_word = 0; ctl_done = 0;
        rd_addr = '0; wr_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset reqs", {ctl_rd_req, ctl_wr_req}, 2'b00);
        rst_n = 1;
        // R1: clients ask before init is done
        rd_req = 1; wr_req = 1; rd_addr = 22'h11; wr_addr = 22'h22;
        repeat (3) @(negedge clk);
        chk("R1 no req before init", {ctl_rd_req, ctl_wr_req}, 2'b00);
        ctl_accept = 1; ctl_word = 1; ctl_done = 1;
        #1;
        chk("R1 R8 no routing before init",
            {rd_accept, rd_word, rd_done, wr_accept, wr_word, wr_done}, 6'b0);
        ctl_accept = 0; ctl_word = 0; ctl_done = 0;
        rd_req = 0; wr_req = 0;
        // R2: init done sampled, polling starts
        init_done = 1;
        @(negedge clk);
        chk("R2 poll cycle no req", {ctl_rd_req, ctl_wr_req}, 2'b00);
        init_done = 0; // R10: later value ignored

        // table walk: R3 R4 R6 R7 R8 R9
        for (int i = 0; i < 6; i++) begin
            logic er, ew;
            logic [AW-1:0] ea;
            er = VEC[i][1]; ew = VEC[i][0];
            rd_req = VEC[i][3]; wr_req = VEC[i][2];
            rd_addr = AW'(32'h1000 + i); wr_addr = AW'(32'h2000 + i);
            ea = er ? rd_addr : wr_addr;
            @(negedge clk);
            chk($sformatf("R3 R4 R10 vec%0d grant", i), {ctl_rd_req, ctl_wr_req}, {er, ew});
            rd_req = 0; wr_req = 0;
            if (er || ew) begin
                chk($sformatf("R7 vec%0d addr", i), ctl_addr, ea);
                rd_addr = '1; wr_addr = '1;
                @(negedge clk);
                chk($sformatf("R6 vec%0d hold req", i), {ctl_rd_req, ctl_wr_req}, {er, ew});
                chk($sformatf("R6 vec%0d hold addr", i), ctl_addr, ea);
                ctl_accept = 1; ctl_word = 1;
                #1;
                chk($sformatf("R8 vec%0d accept/word route", i),
                    {rd_accept, rd_word, wr_accept, wr_word}, {er, er, ew, ew});
                @(negedge clk);
                ctl_accept = 0; ctl_word = 0;
                chk($sformatf("R6 vec%0d req drops", i), {ctl_rd_req, ctl_wr_req}, 2'b00);
                @(negedge clk);
                chk($sformatf("R9 vec%0d still busy", i), {ctl_rd_req, ctl_wr_req}, 2'b00);
                ctl_done = 1;
                #1;
                chk($sformatf("R8 vec%0d done route", i), {rd_done, wr_done}, {er, ew});
                @(negedge clk);
                ctl_done = 0;
            end else begin
                ctl_accept = 1;
                #1;
                chk($sformatf("R8 vec%0d idle no route", i), {rd_accept, wr_accept}, 2'b00);
                @(negedge clk);
                ctl_accept = 0;
                chk($sformatf("R4 vec%0d repoll idle", i), {ctl_rd_req, ctl_wr_req}, 2'b00);
            end
        end

        // R5 R9: write waits behind read, one polling cycle in between
        rd_req = 1; wr_req = 1; rd_addr = 22'h3A; wr_addr = 22'h3B;
        @(negedge clk);
        chk("R3 tie read", {ctl_rd_req, ctl_wr_req}, 2'b10);
        rd_req = 0;
        ctl_accept = 1;
        @(negedge clk);
        ctl_accept = 0;
        repeat (3) @(negedge clk);
        chk("R5 no write while busy", {ctl_rd_req, ctl_wr_req}, 2'b00);
        ctl_done = 1;
        @(negedge clk);
        ctl_done = 0;
        chk("R9 poll gap", {ctl_rd_req, ctl_wr_req}, 2'b00);
        @(negedge clk);
        chk("R9 write granted", {ctl_rd_req, ctl_wr_req}, 2'b01);
        chk("R7 write addr", ctl_addr, 22'h3B);
        wr_req = 0;
        ctl_accept = 1; ctl_done = 1;
        @(negedge clk);
        ctl_accept = 0; ctl_done = 0;

        // R1: reset mid-run returns to init wait
        rst_n = 0;
        @(negedge clk);
        rst_n = 1; rd_req = 1;
        repeat (2) @(negedge clk);
        chk("R1 re-reset waits init", {ctl_rd_req, ctl_wr_req}, 2'b00);
        init_done = 1;
        @(negedge clk);
        init_done = 0;
        @(negedge clk);
        chk("R2 grant after init", {ctl_rd_req, ctl_wr_req}, 2'b10);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule